// File: doc/BRIEF.md
# Single-Channel Throttled DMA Engine

This block copies data between two memory regions on behalf of a host. A 16-bit mode word, a source pointer, a destination pointer and a byte count are presented on configuration inputs and captured when a start command is accepted. The engine then repeats a pattern of one read of the source followed by one write to the destination over a request/grant memory port. Each side may be a byte or a 16-bit word, and each pointer may step forward or stay fixed. The run ends when the count is used up, when a peripheral signals end of data, on a bus error, or on a stop or soft-reset command.

A transfer may start on four kinds of trigger. Two are internal: free-running, or limited to a fixed share of bus cycles inside an 8-cycle window. Two are external: a level on the peripheral request input, or one transfer for each rising edge of that input. A peripheral acknowledge marks the handshaked access, which may be the read phase or the write phase. Completion and error are reported as status bits and a level interrupt.

Mode word fields: `[1:0]` trigger, `[3:2]` bus share, `[5:4]` destination size, `[7:6]` source size, `[8]` destination step enable, `[9]` source step enable, `[10]` interrupt on error enable, `[11]` interrupt on completion enable, `[13:12]` handshake phase. Bits `[15:14]` are unused.

Top module: `dma_channel`

## Requirements
- R1: After reset, busy, mem_req, dack, irq, sts_done and sts_berr are all 0.
- R2: Each transfer reads the source pointer and then writes the destination pointer. Size code 01 is byte and 10 is word. Bus data is right-justified. A byte read written to a word destination is zero-extended. A word read written to a byte destination keeps its low byte. A byte write drives 0 on wdata[15:8].
- R3: After each completed write, a pointer whose step enable is 1 advances by its own size (1 or 2). A pointer whose step enable is 0 keeps its value.
- R4: The count drops by the destination size after each write and stops at 0. When it reaches 0, sts_done goes to 1 and busy and mem_req go to 0 on the same edge. irq rises only if bit 11 is set. A start with count 0 sets sts_done at once and makes no access.
- R5: A bus error (mem_err during a granted access) ends the run without a write. It sets sts_berr, clears busy, and raises irq only if bit 10 is set.
- R6: With trigger 00, mem_req is high in at most 6, 4, 2 or 1 cycles of any 8 consecutive busy cycles, for share codes 00, 01, 10 and 11.
- R7: With trigger 01, transfers run without a bus-share limit, so more than 4 of 8 consecutive cycles carry mem_req when grants are immediate.
- R8: With trigger 10, transfers run only while dreq is high. While dreq is low, no access is made.
- R9: With trigger 11, each rising edge of dreq allows exactly one transfer, however long dreq stays high.
- R10: Handshake code 01 drives dack during the source read, code 10 during the destination write, and codes 00 and 11 never. dack is high only in cycles where mem_req is high.
- R11: A high ext_done while busy ends the run after the transfer in progress. It sets sts_done and raises irq whatever bit 11 holds.
- R12: cmd_stop ends the run once any transfer in progress has completed its write. It leaves sts_done at 0.
- R13: cmd_swreset returns the channel to idle on the next edge. It drops mem_req and dack, even during a stalled access, and clears irq and the status bits.
- R14: A start whose source or destination size code is 00 or 11 is refused: busy stays 0 and no access is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_cfg | input | 16 | Mode word captured at start |
| src_cfg | input | AW | Initial source pointer |
| dst_cfg | input | AW | Initial destination pointer |
| cnt_cfg | input | CNTW | Byte count |
| cmd_start | input | 1 | Start pulse, accepted while idle |
| cmd_stop | input | 1 | Stop after current transfer |
| cmd_swreset | input | 1 | Abort and return to idle |
| dreq | input | 1 | Peripheral transfer request |
| ext_done | input | 1 | Peripheral end-of-data |
| dack | output | 1 | Peripheral acknowledge during the handshaked access |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_word | output | 1 | 1 = word access, 0 = byte |
| mem_addr | output | AW | Access address |
| mem_wdata | output | DW | Write data, right-justified |
| mem_rdata | input | DW | Read data, right-justified, valid with grant |
| mem_gnt | input | 1 | Access completes in this cycle |
| mem_err | input | 1 | Granted access failed |
| busy | output | 1 | Run in progress |
| sts_done | output | 1 | Run completed |
| sts_berr | output | 1 | Run ended by bus error |
| irq | output | 1 | Interrupt request level |

## Verification
The hardest situations to reach from the ports are the cycle-steal rule and a soft reset during a stalled access. For the first, the bench holds dreq high for tens of cycles and checks that only one write appears for each rising edge. For the second, the bench model holds mem_gnt low while a request is outstanding, then issues the soft reset and checks that mem_req and dack are gone one edge later. Throttling is checked by sliding an 8-cycle window over mem_req at every cycle of long runs at each share code.

// File: rtl/dma_pkg.sv
package dma_pkg;

  typedef enum logic [1:0] {
    TRIG_THROTTLE = 2'b00,
    TRIG_FREE     = 2'b01,
    TRIG_LEVEL    = 2'b10,
    TRIG_EDGE     = 2'b11
  } trig_e;

  typedef enum logic [1:0] {
    HSK_NONE = 2'b00,
    HSK_SRC  = 2'b01,
    HSK_DST  = 2'b10,
    HSK_OFF  = 2'b11
  } hsk_e;

  localparam logic [1:0] SZ_BYTE = 2'b01;
  localparam logic [1:0] SZ_WORD = 2'b10;

  typedef struct packed {
    logic [1:0] spare;
    hsk_e       hsk;
    logic       irq_ok_en;
    logic       irq_err_en;
    logic       src_step;
    logic       dst_step;
    logic [1:0] src_sz;
    logic [1:0] dst_sz;
    logic [1:0] share;
    trig_e      trig;
  } mode_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_ARB  = 2'b01,
    ST_RD   = 2'b10,
    ST_WR   = 2'b11
  } state_e;

  function automatic logic size_legal(input logic [1:0] sz);
    return (sz == SZ_BYTE) || (sz == SZ_WORD);
  endfunction

endpackage

// File: rtl/dma_throttle.sv
module dma_throttle #(
  parameter int WIN = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic [1:0] share,
  output logic       allow_next
);
  localparam int CW = $clog2(WIN);

  logic [CW-1:0] slot_q;
  logic [CW-1:0] slot_n;
  logic [CW:0]   quota;

  always_comb begin
    case (share)
      2'b00:   quota = (CW+1)'((WIN * 3) / 4);
      2'b01:   quota = (CW+1)'(WIN / 2);
      2'b10:   quota = (CW+1)'(WIN / 4);
      default: quota = (CW+1)'(WIN / 8);
    endcase
  end

  assign slot_n     = run ? slot_q + 1'b1 : '0;
  assign allow_next = {1'b0, slot_n} < quota;

  always_ff @(posedge clk) begin
    if (rst) slot_q <= '0;
    else     slot_q <= slot_n;
  end
endmodule

// File: rtl/dma_req_sync.sv
module dma_req_sync (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic dreq,
  input  logic take,
  output logic level,
  output logic pend
);
  logic s1, s2;

  assign level = s1;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1   <= 1'b0;
      s2   <= 1'b0;
      pend <= 1'b0;
    end else begin
      s1 <= dreq;
      s2 <= s1;
      if (clr)            pend <= 1'b0;
      else if (s1 && !s2) pend <= 1'b1;
      else if (take)      pend <= 1'b0;
    end
  end
endmodule

// File: rtl/dma_ptr.sv
module dma_ptr #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] init,
  input  logic          step,
  input  logic          step_en,
  input  logic          word,
  output logic [AW-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (rst)                  ptr <= '0;
    else if (load)            ptr <= init;
    else if (step && step_en) ptr <= ptr + (word ? AW'(2) : AW'(1));
  end
endmodule

// File: rtl/dma_channel.sv
module dma_channel
  import dma_pkg::*;
#(
  parameter int AW   = 16,
  parameter int CNTW = 16,
  parameter int DW   = 16,
  parameter int WIN  = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [15:0]     mode_cfg,
  input  logic [AW-1:0]   src_cfg,
  input  logic [AW-1:0]   dst_cfg,
  input  logic [CNTW-1:0] cnt_cfg,
  input  logic            cmd_start,
  input  logic            cmd_stop,
  input  logic            cmd_swreset,
  input  logic            dreq,
  input  logic            ext_done,
  output logic            dack,
  output logic            mem_req,
  output logic            mem_we,
  output logic            mem_word,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  input  logic            mem_gnt,
  input  logic            mem_err,
  output logic            busy,
  output logic            sts_done,
  output logic            sts_berr,
  output logic            irq
);
  localparam int LANE = 8;
  localparam int NPTR = 2;

  mode_t  cfg, mode_q;
  state_e state, nxt;

  logic [CNTW-1:0] cnt_q, cnt_after, unit;
  logic [DW-1:0]   data_q, rd_val, wr_fmt;
  logic            stop_pend, xd_pend;
  logic            start_ok, acc, permit, take;
  logic            rd_ok, wr_ok, fin_done, fin_err, xd_hit;
  logic            allow_next, lvl, pend;
  logic            req_n, dack_n, word_n, irq_ok_eff;
  logic [AW-1:0]   addr_n;

  logic [AW-1:0] ptr_init [NPTR];
  logic [AW-1:0] ptr_val  [NPTR];
  logic          ptr_en   [NPTR];
  logic          ptr_word [NPTR];

  assign cfg      = mode_t'(mode_cfg);
  assign start_ok = cmd_start && (state == ST_IDLE) &&
                    size_legal(cfg.src_sz) && size_legal(cfg.dst_sz);
  assign acc      = mem_req && mem_gnt;

  assign unit      = (mode_q.dst_sz == SZ_WORD) ? CNTW'(2) : CNTW'(1);
  assign cnt_after = (cnt_q > unit) ? cnt_q - unit : '0;

  assign ptr_init[0] = src_cfg;
  assign ptr_init[1] = dst_cfg;
  assign ptr_en[0]   = mode_q.src_step;
  assign ptr_en[1]   = mode_q.dst_step;
  assign ptr_word[0] = (mode_q.src_sz == SZ_WORD);
  assign ptr_word[1] = (mode_q.dst_sz == SZ_WORD);

  generate
    for (genvar g = 0; g < NPTR; g++) begin : g_ptr
      dma_ptr #(.AW(AW)) u_ptr (
        .clk     (clk),
        .rst     (rst),
        .load    (start_ok),
        .init    (ptr_init[g]),
        .step    (wr_ok),
        .step_en (ptr_en[g]),
        .word    (ptr_word[g]),
        .ptr     (ptr_val[g])
      );
    end
  endgenerate

  dma_throttle #(.WIN(WIN)) u_thr (
    .clk        (clk),
    .rst        (rst),
    .run        (busy),
    .share      (mode_q.share),
    .allow_next (allow_next)
  );

  dma_req_sync u_sync (
    .clk   (clk),
    .rst   (rst),
    .clr   (start_ok || cmd_swreset),
    .dreq  (dreq),
    .take  (take),
    .level (lvl),
    .pend  (pend)
  );

  always_comb begin
    case (mode_q.trig)
      TRIG_LEVEL: permit = lvl;
      TRIG_EDGE:  permit = pend;
      default:    permit = 1'b1;
    endcase
  end

  assign rd_val = (mode_q.src_sz == SZ_WORD) ? mem_rdata
                                             : {{(DW-LANE){1'b0}}, mem_rdata[LANE-1:0]};
  assign wr_fmt = (mode_q.dst_sz == SZ_WORD) ? rd_val
                                             : {{(DW-LANE){1'b0}}, rd_val[LANE-1:0]};
  assign xd_hit = xd_pend || ext_done;

  always_comb begin
    nxt      = state;
    rd_ok    = 1'b0;
    wr_ok    = 1'b0;
    fin_done = 1'b0;
    fin_err  = 1'b0;
    take     = 1'b0;
    case (state)
      ST_IDLE: begin
        if (start_ok) begin
          if (cnt_cfg == '0) fin_done = 1'b1;
          else               nxt = ST_ARB;
        end
      end
      ST_ARB: begin
        if (xd_hit) begin
          nxt      = ST_IDLE;
          fin_done = 1'b1;
        end else if (stop_pend || cmd_stop) begin
          nxt = ST_IDLE;
        end else if (permit) begin
          nxt  = ST_RD;
          take = (mode_q.trig == TRIG_EDGE);
        end
      end
      ST_RD: begin
        if (acc) begin
          if (mem_err) begin
            nxt     = ST_IDLE;
            fin_err = 1'b1;
          end else begin
            rd_ok = 1'b1;
            nxt   = ST_WR;
          end
        end
      end
      default: begin
        if (acc) begin
          if (mem_err) begin
            nxt     = ST_IDLE;
            fin_err = 1'b1;
          end else begin
            wr_ok = 1'b1;
            if (cnt_after == '0 || xd_hit) begin
              nxt      = ST_IDLE;
              fin_done = 1'b1;
            end else if (stop_pend || cmd_stop) begin
              nxt = ST_IDLE;
            end else begin
              nxt = ST_ARB;
            end
          end
        end
      end
    endcase
  end

  always_comb begin
    req_n  = ((nxt == ST_RD) || (nxt == ST_WR)) &&
             ((mode_q.trig != TRIG_THROTTLE) || allow_next);
    dack_n = req_n && (((nxt == ST_RD) && (mode_q.hsk == HSK_SRC)) ||
                       ((nxt == ST_WR) && (mode_q.hsk == HSK_DST)));
    addr_n = (nxt == ST_WR) ? ptr_val[1] : ptr_val[0];
    word_n = (nxt == ST_WR) ? ptr_word[1] : ptr_word[0];
    irq_ok_eff = (state == ST_IDLE) ? cfg.irq_ok_en : mode_q.irq_ok_en;
  end

  always_ff @(posedge clk) begin
    if (rst || cmd_swreset) begin
      state     <= ST_IDLE;
      busy      <= 1'b0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      dack      <= 1'b0;
      sts_done  <= 1'b0;
      sts_berr  <= 1'b0;
      irq       <= 1'b0;
      stop_pend <= 1'b0;
      xd_pend   <= 1'b0;
    end else begin
      state   <= nxt;
      busy    <= (nxt != ST_IDLE);
      mem_req <= req_n;
      mem_we  <= (nxt == ST_WR);
      dack    <= dack_n;
      if (start_ok) begin
        sts_done <= 1'b0;
        sts_berr <= 1'b0;
        irq      <= 1'b0;
      end
      if (fin_done) begin
        sts_done <= 1'b1;
        if (irq_ok_eff || (xd_hit && state != ST_IDLE)) irq <= 1'b1;
      end
      if (fin_err) begin
        sts_berr <= 1'b1;
        if (mode_q.irq_err_en) irq <= 1'b1;
      end
      if (nxt == ST_IDLE) begin
        stop_pend <= 1'b0;
        xd_pend   <= 1'b0;
      end else begin
        if (cmd_stop) stop_pend <= 1'b1;
        if (ext_done) xd_pend   <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= '0;
      cnt_q    <= '0;
      data_q   <= '0;
      mem_addr <= '0;
      mem_word <= 1'b0;
    end else begin
      if (start_ok) begin
        mode_q <= cfg;
        cnt_q  <= cnt_cfg;
      end else if (wr_ok) begin
        cnt_q <= cnt_after;
      end
      if (rd_ok) data_q <= wr_fmt;
      if (req_n) begin
        mem_addr <= addr_n;
        mem_word <= word_n;
      end
    end
  end

  assign mem_wdata = data_q;

endmodule

// File: rtl/dma_channel_chk.sv
module dma_channel_chk #(
  parameter int WIN = 8
) (
  input logic        clk,
  input logic        rst,
  input logic        cmd_swreset,
  input logic        busy,
  input logic        mem_req,
  input logic        mem_we,
  input logic        mem_gnt,
  input logic        mem_err,
  input logic        dack,
  input logic        sts_done,
  input logic        sts_berr,
  input logic        irq,
  input logic [15:0] mode
);
  logic [WIN-1:0] hist;
  int unsigned    quota;

  always_comb begin
    case (mode[3:2])
      2'b00:   quota = (WIN * 3) / 4;
      2'b01:   quota = WIN / 2;
      2'b10:   quota = WIN / 4;
      default: quota = WIN / 8;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || !busy) hist <= '0;
    else              hist <= {hist[WIN-2:0], mem_req};
  end

  assert_idle_no_req_R4: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req);

  assert_dack_in_access_R10: assert property (@(posedge clk) disable iff (rst)
    dack |-> mem_req);

  assert_dack_phase_R10: assert property (@(posedge clk) disable iff (rst)
    dack |-> ((mode[13:12] == 2'b01 && !mem_we) || (mode[13:12] == 2'b10 && mem_we)));

  assert_share_cap_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && mode[1:0] == 2'b00) |->
      ($countones({hist[WIN-2:0], mem_req}) <= quota));

  assert_berr_ends_R5: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_gnt && mem_err && !cmd_swreset) |=> (!busy && sts_berr));

  assert_swreset_idle_R13: assert property (@(posedge clk) disable iff (rst)
    cmd_swreset |=> (!busy && !mem_req && !dack && !irq));

  assert_irq_has_cause_R4: assert property (@(posedge clk) disable iff (rst)
    irq |-> (sts_done || sts_berr));

endmodule

bind dma_channel dma_channel_chk #(.WIN(WIN)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cmd_swreset (cmd_swreset),
  .busy        (busy),
  .mem_req     (mem_req),
  .mem_we      (mem_we),
  .mem_gnt     (mem_gnt),
  .mem_err     (mem_err),
  .dack        (dack),
  .sts_done    (sts_done),
  .sts_berr    (sts_berr),
  .irq         (irq),
  .mode        (mode_q)
);

// File: tb/sim_dma_channel.sv
module sim_dma_channel;
  localparam int CLK_NS = 10;
  localparam int AW = 16;
  localparam int CNTW = 16;
  localparam int DW = 16;

  logic clk = 1'b0, rst = 1'b1;
  logic [15:0] mode_cfg = '0;
  logic [AW-1:0] src_cfg = '0, dst_cfg = '0;
  logic [CNTW-1:0] cnt_cfg = '0;
  logic cmd_start = 0, cmd_stop = 0, cmd_swreset = 0, dreq = 0, ext_done = 0;
  logic dack, mem_req, mem_we, mem_word, mem_gnt, mem_err;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic busy, sts_done, sts_berr, irq;

  dma_channel u0 (.*);

  always #(CLK_NS/2) clk = ~clk;

  logic [7:0] mem [256];
  logic [15:0] lfsr = 16'hACE1;
  int gnt_mode = 0;

  always @(posedge clk) lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  assign mem_gnt   = (gnt_mode == 0) ? 1'b1 : (gnt_mode == 1) ? lfsr[0] : 1'b0;
  assign mem_err   = mem_req && (mem_addr[15:12] == 4'hF);
  assign mem_rdata = mem_word ? {mem[mem_addr[7:0] + 8'd1], mem[mem_addr[7:0]]}
                              : {8'h00, mem[mem_addr[7:0]]};

  always @(posedge clk)
    if (mem_req && mem_gnt && mem_we && !mem_err) begin
      mem[mem_addr[7:0]] <= mem_wdata[7:0];
      if (mem_word) mem[mem_addr[7:0] + 8'd1] <= mem_wdata[15:8];
    end

  typedef struct { logic [AW-1:0] a; logic [15:0] d; logic w; } exp_t;
  exp_t expq[$];

  int n_chk = 0, n_fail = 0;
  int n_rd = 0, n_wr = 0, n_dack_rd = 0, n_dack_wr = 0, win_max = 0;
  logic [7:0] bh = '0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: scoreboard comparison and bus observation
  always @(negedge clk) begin
    if (!rst) begin
      if (!busy) bh = '0;
      else bh = {bh[6:0], mem_req};
      if ($countones(bh) > win_max) win_max = $countones(bh);
      if (mem_req && mem_gnt && !mem_err) begin
        if (mem_we) begin
          n_wr++;
          n_chk++;
          if (expq.size() == 0) begin
            n_fail++;
            $display("FAIL R2 unexpected write actual=%0h expected=none", mem_addr);
          end else begin
            exp_t e;
            e = expq.pop_front();
            if (e.a !== mem_addr || e.d !== mem_wdata || e.w !== mem_word) begin
              n_fail++;
              $display("FAIL R2/R3 write actual=%0h:%0h:%0b expected=%0h:%0h:%0b",
                       mem_addr, mem_wdata, mem_word, e.a, e.d, e.w);
            end
          end
        end else n_rd++;
        if (dack) begin
          if (mem_we) n_dack_wr++;
          else n_dack_rd++;
        end
      end
    end
  end

  function automatic logic [15:0] md(input logic [1:0] trig, share, dsz, ssz,
                                     input logic dinc, sinc, ierr, iok,
                                     input logic [1:0] hsk);
    return {2'b00, hsk, iok, ierr, sinc, dinc, ssz, dsz, share, trig};
  endfunction

  // Driver: pushes expected writes computed from the requirements
  task automatic push_expected(input logic [15:0] m, input int s, input int d, input int c);
    bit sw, dw;
    sw = (m[7:6] == 2'b10);
    dw = (m[5:4] == 2'b10);
    while (c > 0) begin
      exp_t e;
      logic [15:0] v;
      v = sw ? {mem[(s+1) & 255], mem[s & 255]} : {8'h00, mem[s & 255]};
      e.a = AW'(d);
      e.d = dw ? v : {8'h00, v[7:0]};
      e.w = dw;
      expq.push_back(e);
      if (m[9]) s += sw ? 2 : 1;
      if (m[8]) d += dw ? 2 : 1;
      c = (c > (dw ? 2 : 1)) ? c - (dw ? 2 : 1) : 0;
    end
  endtask

  task automatic start_run(input logic [15:0] m, input int s, input int d, input int c);
    @(negedge clk);
    mode_cfg = m; src_cfg = AW'(s); dst_cfg = AW'(d); cnt_cfg = CNTW'(c);
    win_max = 0;
    cmd_start = 1;
    @(negedge clk);
    cmd_start = 0;
  endtask

  task automatic wait_idle();
    int k = 0;
    while (busy && k < 5000) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic pulse(ref logic sig);
    sig = 1;
    @(negedge clk);
    sig = 0;
  endtask

  task automatic fill();
    for (int i = 0; i < 128; i++) mem[i] = 8'(i * 7 + 3);
    for (int i = 128; i < 256; i++) mem[i] = 8'hEE;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int w0, r0, dr0, dw0;
    fill();
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !mem_req && !dack, "R1 idle outputs", {busy, mem_req, dack}, 0);
    chk(!irq && !sts_done && !sts_berr, "R1 status", {irq, sts_done, sts_berr}, 0);

    // R2 R4 R7: free-running word copy, completion interrupt enabled
    push_expected(md(2'b01, 0, 2'b10, 2'b10, 1, 1, 0, 1, 0), 0, 128, 16);
    start_run(md(2'b01, 0, 2'b10, 2'b10, 1, 1, 0, 1, 0), 0, 128, 16);
    wait_idle();
    chk(sts_done && irq && !busy, "R4 done with irq", {sts_done, irq, busy}, 3'b110);
    chk(expq.size() == 0, "R2 all writes seen", expq.size(), 0);
    chk(win_max >= 5, "R7 unthrottled density", win_max, 5);

    // R2 R4: byte source to word destination, random grants, irq disabled
    fill(); gnt_mode = 1;
    push_expected(md(2'b01, 0, 2'b10, 2'b01, 1, 1, 0, 0, 0), 5, 160, 6);
    start_run(md(2'b01, 0, 2'b10, 2'b01, 1, 1, 0, 0, 0), 5, 160, 6);
    wait_idle();
    chk(sts_done && !irq, "R4 done without irq", {sts_done, irq}, 2'b10);
    chk(expq.size() == 0, "R2 zero-extend run", expq.size(), 0);

    // R3: word source to fixed byte destination
    fill();
    push_expected(md(2'b01, 0, 2'b01, 2'b10, 0, 1, 0, 0, 0), 10, 200, 3);
    start_run(md(2'b01, 0, 2'b01, 2'b10, 0, 1, 0, 0, 0), 10, 200, 3);
    wait_idle();
    chk(expq.size() == 0 && mem[200] == 8'(14*7+3), "R3 fixed destination", mem[200], 8'(14*7+3));
    gnt_mode = 0;

    // R6: throttled shares
    for (int b = 0; b < 4; b++) begin
      int q;
      q = (b == 0) ? 6 : (b == 1) ? 4 : (b == 2) ? 2 : 1;
      fill();
      push_expected(md(2'b00, 2'(b), 2'b10, 2'b10, 1, 1, 0, 1, 0), 0, 128, 32);
      start_run(md(2'b00, 2'(b), 2'b10, 2'b10, 1, 1, 0, 1, 0), 0, 128, 32);
      wait_idle();
      chk(win_max <= q && win_max >= 1, "R6 window cap", win_max, q);
      chk(expq.size() == 0 && sts_done, "R6 throttled run completes", expq.size(), 0);
    end

    // R8 R10: level trigger, handshake on source read
    fill();
    push_expected(md(2'b10, 0, 2'b10, 2'b10, 1, 1, 0, 0, 2'b01), 0, 128, 8);
    r0 = n_rd; w0 = n_wr; dr0 = n_dack_rd; dw0 = n_dack_wr;
    start_run(md(2'b10, 0, 2'b10, 2'b10, 1, 1, 0, 0, 2'b01), 0, 128, 8);
    repeat (20) @(negedge clk);
    chk(n_rd == r0 && busy, "R8 no access while dreq low", n_rd - r0, 0);
    dreq = 1;
    wait_idle();
    dreq = 0;
    chk(sts_done && expq.size() == 0, "R8 runs while dreq high", expq.size(), 0);
    chk(n_dack_rd - dr0 == 4 && n_dack_wr == dw0, "R10 dack on reads", n_dack_rd - dr0, 4);

    // R9 R10 R13: edge trigger, handshake on destination write, soft reset
    fill();
    push_expected(md(2'b11, 0, 2'b01, 2'b01, 1, 1, 0, 0, 2'b10), 0, 128, 8);
    w0 = n_wr; dr0 = n_dack_rd; dw0 = n_dack_wr;
    start_run(md(2'b11, 0, 2'b01, 2'b01, 1, 1, 0, 0, 2'b10), 0, 128, 8);
    dreq = 1;
    repeat (40) @(negedge clk);
    chk(n_wr - w0 == 1, "R9 one transfer per edge", n_wr - w0, 1);
    dreq = 0;
    repeat (5) @(negedge clk);
    dreq = 1;
    repeat (40) @(negedge clk);
    chk(n_wr - w0 == 2 && busy, "R9 second edge", n_wr - w0, 2);
    chk(n_dack_wr - dw0 == 2 && n_dack_rd == dr0, "R10 dack on writes", n_dack_wr - dw0, 2);
    gnt_mode = 2;
    dreq = 0;
    repeat (5) @(negedge clk);
    dreq = 1;
    repeat (10) @(negedge clk);
    chk(mem_req, "R13 stalled access present", mem_req, 1);
    pulse(cmd_swreset);
    chk(!busy && !mem_req && !dack, "R13 soft reset idles", {busy, mem_req, dack}, 0);
    gnt_mode = 0; dreq = 0;
    expq.delete();

    // R5: bus error with and without its interrupt enable
    w0 = n_wr;
    start_run(md(2'b01, 0, 2'b10, 2'b10, 1, 1, 1, 0, 0), 16'hF000, 128, 4);
    wait_idle();
    chk(sts_berr && irq && !sts_done && n_wr == w0, "R5 error with irq", {sts_berr, irq, sts_done}, 3'b110);
    start_run(md(2'b01, 0, 2'b10, 2'b10, 1, 1, 0, 0, 0), 16'hF000, 128, 4);
    wait_idle();
    chk(sts_berr && !irq && n_wr == w0, "R5 error without irq", {sts_berr, irq}, 2'b10);

    // R11: external end of data, completion irq disabled
    fill();
    push_expected(md(2'b00, 2'b11, 2'b10, 2'b10, 1, 1, 0, 0, 0), 0, 128, 64);
    w0 = n_wr;
    start_run(md(2'b00, 2'b11, 2'b10, 2'b10, 1, 1, 0, 0, 0), 0, 128, 64);
    while (n_wr - w0 < 3) @(negedge clk);
    pulse(ext_done);
    wait_idle();
    chk(sts_done && irq && (n_wr - w0) < 32, "R11 early end", n_wr - w0, 4);
    expq.delete();

    // R12: stop with random grants
    fill(); gnt_mode = 1;
    push_expected(md(2'b01, 0, 2'b10, 2'b10, 1, 1, 0, 1, 0), 0, 128, 32);
    r0 = n_rd; w0 = n_wr;
    start_run(md(2'b01, 0, 2'b10, 2'b10, 1, 1, 0, 1, 0), 0, 128, 32);
    repeat (9) @(negedge clk);
    pulse(cmd_stop);
    wait_idle();
    chk(!sts_done && !irq && (n_wr - w0) < 16, "R12 stopped early", n_wr - w0, 0);
    chk(n_rd - r0 == n_wr - w0, "R12 write finished", n_rd - r0, n_wr - w0);
    expq.delete(); gnt_mode = 0;

    // R14: reserved size refused; R4 zero count
    r0 = n_rd;
    start_run(md(2'b01, 0, 2'b10, 2'b00, 1, 1, 0, 1, 0), 0, 128, 8);
    repeat (3) @(negedge clk);
    chk(!busy && n_rd == r0, "R14 reserved size refused", busy, 0);
    start_run(md(2'b01, 0, 2'b11, 2'b10, 1, 1, 0, 1, 0), 0, 128, 8);
    repeat (3) @(negedge clk);
    chk(!busy && n_rd == r0, "R14 reserved dst size refused", busy, 0);
    start_run(md(2'b01, 0, 2'b10, 2'b10, 1, 1, 0, 1, 0), 0, 128, 0);
    chk(!busy && sts_done && irq && n_rd == r0, "R4 zero count", {busy, sts_done, irq}, 3'b011);

    repeat (4) @(negedge clk);
    summary();
  end
endmodule